// File: doc/BRIEF.md
# Banked GPIO Pin Output Controller

This block controls a set of general-purpose pins from a 64-bit register interface with a single-cycle write strobe and a read strobe. Each pin has one bit of output data. Software never rewrites the whole data word. It changes bits through a write-one-to-set register and a write-one-to-clear register, so two agents can update different pins without a read-modify-write race. Pins are grouped sixty-four to a bank, and each bank has its own copies of the data registers at a fixed stride.

Every line has a configuration word. It enables the output, selects an inversion applied on both the drive path and the sample path, chooses open-drain instead of push-pull drive, and holds a function-select field. When the function-select field is nonzero, another function owns the pin, so this block stops driving it and stops accepting data changes for it. A read-only constant word reports the line count and a base interrupt-vector index. Each pin leaves the block as a drive value plus a drive enable, suitable for a tristate pad.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After synchronous reset, every data bit and every configuration field is zero, no pin is driven (pad_oe and pad_out all zero), and bus_rdata is zero.
- R2: A write to bank base + 0x08 sets data bit i of line 64·bank + i for each 1 in bus_wdata[i]. Lines whose write bit is 0 keep their value. The change is visible at the pins one cycle after the write.
- R3: A write to bank base + 0x10 clears data bit i of line 64·bank + i for each 1 in bus_wdata[i]. Lines whose write bit is 0 keep their value.
- R4: A read at bank base + 0x08 or + 0x10 returns that bank's output data bits in bit positions 0..63. Positions with no line read 0.
- R5: The configuration word of line n sits at 0x400 + 8·n. Bit 0 is output enable, bit 1 is invert, bit 12 is open-drain, and bits 25:16 are function select. A read returns these fields, and all other bits read 0.
- R6: In push-pull mode (open-drain bit 0, function select 0), pad_oe equals output enable and pad_out equals data XOR invert.
- R7: In open-drain mode, pad_out is 0. pad_oe is 1 only when output enable is set and data XOR invert is 0.
- R8: A read at bank base + 0x00 returns pad_in of each line of the bank XORed with that line's invert bit. Positions with no line read 0.
- R9: While a line's function select is nonzero, its pad_oe and pad_out are 0, and set and clear writes leave its data bit unchanged.
- R10: A read at 0x90 returns the line count in bits 7:0 and the base vector index in bits 15:8. All other bits read 0.
- R11: The bank stride is 0x1400, and bank 1's registers appear at 0x1400, 0x1408 and 0x1410. Addresses with nonzero bits 2:0, and addresses mapping no register, read 0, and writes to them change nothing.
- R12: bus_rdata takes the read result on the clock edge that samples bus_rd, and it holds its value on every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (16) | Byte address of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| pad_in | input | NUM_LINES (72) | Sampled pad levels |
| pad_out | output | NUM_LINES (72) | Drive value per pin |
| pad_oe | output | NUM_LINES (72) | Drive enable per pin |

## Verification
A wrong data or configuration bit shows up on pad_out or pad_oe of that line in the cycle right after the write that caused it. It stays visible until a later write or reset, so the bench compares the whole pin vector after every write. A corrupted function-select or invert field hides in the read path until the next read, so every configuration change is followed by a readback. Dropped or misrouted set and clear strobes, especially across the bank boundary and on lines owned by another function, appear as a wrong data word one cycle after the read strobe.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int WORD_W      = 64;
    localparam int FSEL_W      = 10;
    localparam int BANK_STRIDE = 'h1400;
    localparam int OFF_RX      = 'h00;
    localparam int OFF_SET     = 'h08;
    localparam int OFF_CLR     = 'h10;
    localparam int OFF_CONST   = 'h90;
    localparam int OFF_CFG     = 'h400;

    // field positions inside a line configuration word
    localparam int POS_OE   = 0;
    localparam int POS_INV  = 1;
    localparam int POS_OD   = 12;
    localparam int POS_FSEL = 16;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RX,
        ACC_SET,
        ACC_CLR,
        ACC_CONST,
        ACC_CFG
    } acc_kind_e;

    typedef struct packed {
        logic [FSEL_W-1:0] fsel;
        logic              od;
        logic              inv;
        logic              oe;
    } line_cfg_t;

    function automatic line_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        line_cfg_t c;
        c.oe   = w[POS_OE];
        c.inv  = w[POS_INV];
        c.od   = w[POS_OD];
        c.fsel = w[POS_FSEL +: FSEL_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input line_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_OE]               = c.oe;
        w[POS_INV]              = c.inv;
        w[POS_OD]               = c.od;
        w[POS_FSEL +: FSEL_W]   = c.fsel;
        return w;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_LINES = 72,
    parameter int NBANKS    = 2,
    parameter int BW        = 1,
    parameter int LW        = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [BW-1:0]     bank,
    output logic [LW-1:0]     line
);

    logic [31:0] bank_n;
    logic [31:0] off;
    logic [31:0] cfg_rel;

    always_comb begin
        bank_n  = 32'(addr) / 32'(BANK_STRIDE);
        off     = 32'(addr) % 32'(BANK_STRIDE);
        cfg_rel = off - 32'(OFF_CFG);
        kind    = ACC_NONE;
        line    = '0;
        bank    = BW'(bank_n);
        if (addr[2:0] == 3'b000) begin
            if (bank_n < 32'(NBANKS)) begin
                if (off == 32'(OFF_RX))  kind = ACC_RX;
                if (off == 32'(OFF_SET)) kind = ACC_SET;
                if (off == 32'(OFF_CLR)) kind = ACC_CLR;
            end
            if (bank_n == 32'd0 && off == 32'(OFF_CONST)) kind = ACC_CONST;
            if (bank_n == 32'd0 && off >= 32'(OFF_CFG) &&
                off < 32'(OFF_CFG) + 32'(8 * NUM_LINES)) begin
                kind = ACC_CFG;
                line = LW'(cfg_rel >> 3);
            end
        end
    end

endmodule

// File: rtl/gpio_line.sv
module gpio_line
    import gpio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_we,
    input  line_cfg_t cfg_in,
    input  logic      set_req,
    input  logic      clr_req,
    input  logic      pad_in,
    output line_cfg_t cfg_q,
    output logic      dout,
    output logic      rx,
    output logic      pad_out,
    output logic      pad_oe
);

    logic owned;
    logic eff;

    assign owned = (cfg_q.fsel == '0);
    assign eff   = dout ^ cfg_q.inv;
    assign rx    = pad_in ^ cfg_q.inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            dout  <= 1'b0;
        end else begin
            if (cfg_we) cfg_q <= cfg_in;
            if (owned) begin
                if (set_req)      dout <= 1'b1;
                else if (clr_req) dout <= 1'b0;
            end
        end
    end

    always_comb begin
        pad_out = 1'b0;
        pad_oe  = 1'b0;
        if (owned) begin
            if (cfg_q.od) begin
                pad_oe = cfg_q.oe & ~eff;
            end else begin
                pad_out = eff;
                pad_oe  = cfg_q.oe;
            end
        end
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (set_req && owned) |=> dout);                                  // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req && owned) |=> !dout);                     // R3
    AST_FSEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!owned) |=> (dout == $past(dout)));                           // R9
    AST_OD_LOW: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.od && pad_oe) |-> !pad_out);                            // R7

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_LINES = 72,
    parameter int VEC_BASE  = 48
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [63:0]           bus_wdata,
    output logic [63:0]           bus_rdata,
    input  logic [NUM_LINES-1:0]  pad_in,
    output logic [NUM_LINES-1:0]  pad_out,
    output logic [NUM_LINES-1:0]  pad_oe
);

    localparam int NBANKS = (NUM_LINES + WORD_W - 1) / WORD_W;
    localparam int BW     = (NBANKS > 1) ? $clog2(NBANKS) : 1;
    localparam int LW     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int PAD_W  = NBANKS * WORD_W;

    acc_kind_e     kind;
    logic [BW-1:0] bank;
    logic [LW-1:0] line;

    gpio_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .NBANKS(NBANKS), .BW(BW), .LW(LW)
    ) u_dec (
        .addr(bus_addr), .kind(kind), .bank(bank), .line(line)
    );

    line_cfg_t            cfg_arr [NUM_LINES];
    logic [NUM_LINES-1:0] cfg_we_vec;
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] dout_vec;
    logic [NUM_LINES-1:0] rx_vec;
    logic [PAD_W-1:0]     dout_all;
    logic [PAD_W-1:0]     rx_all;
    line_cfg_t            cfg_wr;

    assign cfg_wr = word_to_cfg(bus_wdata);

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        localparam int BNK = n / WORD_W;
        localparam int BIT = n % WORD_W;

        assign cfg_we_vec[n] = bus_wr && kind == ACC_CFG && line == LW'(n);
        assign set_vec[n]    = bus_wr && kind == ACC_SET && bank == BW'(BNK) && bus_wdata[BIT];
        assign clr_vec[n]    = bus_wr && kind == ACC_CLR && bank == BW'(BNK) && bus_wdata[BIT];

        gpio_line u_line (
            .clk(clk), .rst(rst),
            .cfg_we(cfg_we_vec[n]), .cfg_in(cfg_wr),
            .set_req(set_vec[n]), .clr_req(clr_vec[n]),
            .pad_in(pad_in[n]),
            .cfg_q(cfg_arr[n]), .dout(dout_vec[n]), .rx(rx_vec[n]),
            .pad_out(pad_out[n]), .pad_oe(pad_oe[n])
        );
    end

    for (genvar k = 0; k < PAD_W; k++) begin : g_pad
        if (k < NUM_LINES) begin : g_real
            assign dout_all[k] = dout_vec[k];
            assign rx_all[k]   = rx_vec[k];
        end else begin : g_void
            assign dout_all[k] = 1'b0;
            assign rx_all[k]   = 1'b0;
        end
    end

    logic [63:0] rd_word;

    always_comb begin
        rd_word = '0;
        case (kind)
            ACC_RX:           rd_word = rx_all[32'(bank) * WORD_W +: WORD_W];
            ACC_SET, ACC_CLR: rd_word = dout_all[32'(bank) * WORD_W +: WORD_W];
            ACC_CONST: begin
                rd_word[7:0]  = 8'(NUM_LINES);
                rd_word[15:8] = 8'(VEC_BASE);
            end
            ACC_CFG:          rd_word = cfg_to_word(cfg_arr[line]);
            default:          rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd) |=> $stable(bus_rdata));                             // R12
    AST_CFG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cfg_we_vec));                                         // R5
    AST_SETCLR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(|(set_vec & clr_vec)));                                      // R2

endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 72;
    localparam int VBASE = 48;
    localparam int NB    = 2;
    localparam int STR   = 'h1400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out;
    logic [N-1:0]  pad_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_bank_ctrl #(.ADDR_W(16), .NUM_LINES(N), .VEC_BASE(VBASE)) u_gpio_bank_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model built from the requirements
    logic        m_dat [N];
    logic        m_oe  [N];
    logic        m_inv [N];
    logic        m_od  [N];
    logic [9:0]  m_fs  [N];

    logic [63:0] exp_q [$];
    string       tag_q [$];
    logic        seen = 1'b0;

    function automatic logic [63:0] mdl_read(input int a);
        logic [63:0] r;
        int b, o;
        r = '0;
        b = a / STR;
        o = a % STR;
        if (a % 8 != 0) return r;
        if (b < NB && (o == 'h0 || o == 'h8 || o == 'h10)) begin
            for (int i = 0; i < 64; i++) begin
                if (b * 64 + i < N)
                    r[i] = (o == 0) ? (pad_in[b * 64 + i] ^ m_inv[b * 64 + i]) : m_dat[b * 64 + i];
            end
        end
        if (b == 0 && o == 'h90) r = 64'(N) | (64'(VBASE) << 8);
        if (b == 0 && o >= 'h400 && o < 'h400 + 8 * N) begin
            int n = (o - 'h400) / 8;
            r[0] = m_oe[n]; r[1] = m_inv[n]; r[12] = m_od[n]; r[25:16] = m_fs[n];
        end
        return r;
    endfunction

    function automatic void mdl_write(input int a, input logic [63:0] d);
        int b, o;
        b = a / STR;
        o = a % STR;
        if (a % 8 != 0) return;
        if (b < NB && (o == 'h8 || o == 'h10)) begin
            for (int i = 0; i < 64; i++) begin
                int n = b * 64 + i;
                if (n < N && d[i] && m_fs[n] == 0) m_dat[n] = (o == 'h8);
            end
        end
        if (b == 0 && o >= 'h400 && o < 'h400 + 8 * N) begin
            int n = (o - 'h400) / 8;
            m_oe[n] = d[0]; m_inv[n] = d[1]; m_od[n] = d[12]; m_fs[n] = d[25:16];
        end
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input int a, input logic [63:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 16'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        mdl_write(a, d);
    endtask

    task automatic bread(input int a, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 16'(a);
        exp_q.push_back(mdl_read(a));
        tag_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_pads(input string req);
        logic [N-1:0] eo, ee;
        for (int n = 0; n < N; n++) begin
            logic eff;
            eff = m_dat[n] ^ m_inv[n];
            eo[n] = 1'b0; ee[n] = 1'b0;
            if (m_fs[n] == 0) begin
                if (m_od[n]) ee[n] = m_oe[n] & ~eff;
                else begin eo[n] = eff; ee[n] = m_oe[n]; end
            end
        end
        check({req, " pad_out"}, 128'(pad_out), 128'(eo));
        check({req, " pad_oe"},  128'(pad_oe),  128'(ee));
    endtask

    // scoreboard monitor
    always @(posedge clk) seen <= bus_rd;
    always @(negedge clk) begin
        if (seen && exp_q.size() > 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 128'(bus_rdata), 128'(e));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] hold;
        for (int n = 0; n < N; n++) begin
            m_dat[n] = 0; m_oe[n] = 0; m_inv[n] = 0; m_od[n] = 0; m_fs[n] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", 128'(bus_rdata), 128'(0));
        check_pads("R1");
        bread('h08, "R1 data");
        bread('h428, "R1 cfg");

        // R10 constant word
        bread('h90, "R10 const");

        // R5 config fields, other bits read zero
        bwrite('h400 + 8 * 3, 64'hFFFF_FFFF_FFFF_FFFF);
        bread('h400 + 8 * 3, "R5 cfg readback");
        check_pads("R9 fsel releases pin");

        // R2 set, R9 ignored on line 3
        bwrite('h08, 64'h0F0F);
        bread('h08, "R2 set / R9 ignore");
        // R3 clear, read via clear offset R4
        bwrite('h10, 64'h0005);
        bread('h10, "R3 clear R4 readback");

        // R6 push-pull with and without invert
        bwrite('h400 + 8 * 1, 64'h1);
        bwrite('h400 + 8 * 8, 64'h1);
        check_pads("R6 push-pull");
        bwrite('h400 + 8 * 1, 64'h3);
        check_pads("R6 invert");

        // R7 open-drain
        bwrite('h400 + 8 * 9, 64'h1001);
        check_pads("R7 od released");
        bwrite('h10, 64'h0200);
        check_pads("R7 od pulls low");
        bwrite('h400 + 8 * 10, 64'h1003);
        check_pads("R7 od invert");

        // R8 receive path with inversion
        pad_in = 72'hA5_5A5A_F00F_1234_8001;
        bread('h00, "R8 rx bank0");
        bread('h1400, "R8 rx bank1");

        // R11 second bank
        bwrite('h1408, 64'hFFFF_FFFF_FFFF_FFFF);
        bread('h1408, "R11 bank1 set");
        bwrite('h400 + 8 * 70, 64'h1);
        check_pads("R11 bank1 pin");
        bwrite('h1410, 64'h0F);
        bread('h1410, "R11 bank1 clear");

        // R11 unmapped and misaligned accesses
        bwrite('h18, 64'hFFFF);
        bwrite('h0C, 64'hFFFF);
        bwrite('h2808, 64'hFFFF);
        bread('h08, "R11 unmapped write no effect");
        bread('h98, "R11 unmapped read");
        bread('h400 + 8 * N, "R11 past last cfg");
        bread('h0C, "R11 misaligned read");

        // R9 function select with output enable, then release
        bwrite('h400 + 8 * 8, 64'h0001_0001);
        check_pads("R9 fsel overrides oe");
        bwrite('h10, 64'h0100);
        bwrite('h400 + 8 * 8, 64'h1);
        check_pads("R9 data kept after release");
        bwrite('h400 + 8 * 3, 64'h1);
        bread('h08, "R9 line3 data unchanged");

        // R12 read data holds
        bread('h90, "R12 read");
        @(negedge clk);
        hold = bus_rdata;
        repeat (4) @(negedge clk);
        check("R12 hold", 128'(bus_rdata), 128'(hold));

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule